// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps only the identity of cached blocks, not their data, for a cache of `SETS` sets by `WAYS` ways. Each accepted request carries a byte address. The block answers hit or miss in the same cycle. At the next clock edge it rewrites the selected set according to a replacement policy that is fixed at elaboration: least-recently-used or first-in first-out. Two counters tally hits and misses. A direct-mapped directory is the case `WAYS = 1`.

Each set is held as an ordered list, with the most recent entry at position 0 and the oldest at position `WAYS-1`. The low `log2(BLOCK_BYTES)` address bits select a byte within the block and play no part in lookup. The next `log2(SETS)` bits pick the set. Each way stores the whole block address, which is the address with the offset bits removed, so no bits are dropped to form a shorter tag.

Top module: `cache_tag_dir`

## Requirements
- R1: `rsp_hit` is 1 in the cycle a request is presented exactly when some valid way of the selected set holds that request's block address (`req_addr >> log2(BLOCK_BYTES)`). Otherwise it is 0.
- R2: The set is selected by bits `[log2(BLOCK_BYTES) +: log2(SETS)]` of the address. Addresses that differ only in the offset bits are the same block. Blocks in different sets never evict one another.
- R3: After synchronous active-low reset, both counters read 0 and every way is empty, so the first access to any address misses.
- R4: Under LRU, a hit moves the matching entry to position 0. The other entries keep their relative order.
- R5: Under FIFO, a hit leaves the order and contents of the set unchanged.
- R6: Under either policy, a miss inserts the block address at position 0 and shifts the others down one place. The entry at position `WAYS-1` is discarded. While a set is not full, no valid entry is lost.
- R7: The comparison uses the full block address. Two addresses with the same set index that differ in any higher bit are different blocks.
- R8: Each accepted request adds 1 to `hit_count` on a hit or to `miss_count` on a miss, visible after the accepting clock edge.
- R9: Each counter saturates at `2**CNT_W - 1` and stays there.
- R10: `req_ready` is always 1. A cycle with `req_valid` low changes neither the counters nor any set.
- R11: With `WAYS = 1`, each set holds one block, and any miss replaces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Request can be taken (always 1) |
| rsp_hit | output | 1 | Lookup result for the presented address: 1 hit, 0 miss |
| hit_count | output | CNT_W | Saturating count of hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The bench builds three copies with 4 sets and 32-byte blocks, all driven by the same stream. The first is 4-way LRU, the second is 4-way FIFO and the third is direct mapped with 4-bit counters. With only four sets and a small pool of high address bits, sets fill and evict often, so the LRU and FIFO orderings visibly give different hit patterns on the same stream. The narrow counters of the direct-mapped copy bring saturation within reach in a short run.

// File: rtl/cdir_pkg.sv
// Shared types for the cache tag directory.
// Assumes: nothing beyond IEEE 1800-2017.
package cdir_pkg;
    // Replacement policy chosen at elaboration time
    typedef enum logic {
        REPL_LRU  = 1'b0,
        REPL_FIFO = 1'b1
    } repl_e;
endpackage

// File: rtl/cdir_lookup.sv
// Compares one set's ways against a block address and reports hit
// and the position of the matching way.
// Assumes: at most one valid way holds any given block address.
module cdir_lookup #(
    parameter int WAYS  = 4,
    parameter int BLK_W = 27,
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0][BLK_W-1:0]  row_blk,
    input  logic [WAYS-1:0]             row_vld,
    input  logic [BLK_W-1:0]            key,
    output logic                        hit,
    output logic [POS_W-1:0]            hit_pos
);

    logic [WAYS-1:0] match;

    // Per-way equality against the key, qualified by valid
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = row_vld[w] && (row_blk[w] == key);
    end

    // Encode the lowest matching position
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit     = 1'b1;
                hit_pos = POS_W'(w);
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R1

endmodule

// File: rtl/cdir_reorder.sv
// Computes the next contents of one set from its current contents,
// the lookup result and the policy.
// Assumes: valid ways form a prefix starting at position 0.
module cdir_reorder #(
    parameter int              WAYS   = 4,
    parameter int              BLK_W  = 27,
    parameter cdir_pkg::repl_e POLICY = cdir_pkg::REPL_LRU,
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][BLK_W-1:0]  old_blk,
    input  logic [WAYS-1:0]             old_vld,
    input  logic                        hit,
    input  logic [POS_W-1:0]            hit_pos,
    input  logic [BLK_W-1:0]            key,
    output logic [WAYS-1:0][BLK_W-1:0]  new_blk,
    output logic [WAYS-1:0]             new_vld
);

    logic             move;
    logic [POS_W-1:0] src_pos;

    // Policy variant: whether a hit reorders the set
    if (POLICY == cdir_pkg::REPL_FIFO) begin : g_fifo
        assign move = !hit;
    end else begin : g_lru
        assign move = 1'b1;
    end

    // A miss behaves like removing the last position
    assign src_pos = hit ? hit_pos : POS_W'(WAYS - 1);

    // Shift entries above the source position down, put key in front
    always_comb begin
        new_blk = old_blk;
        new_vld = old_vld;
        if (move) begin
            new_blk[0] = key;
            new_vld[0] = 1'b1;
            for (int i = 1; i < WAYS; i++) begin
                if (i <= int'(src_pos)) begin
                    new_blk[i] = old_blk[i-1];
                    new_vld[i] = old_vld[i-1];
                end
            end
        end
    end

endmodule

// File: rtl/cdir_sat_counter.sv
// Saturating up-counter, one step per cycle with inc high.
// Assumes: W >= 1.
module cdir_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MAXV = '1;

    // Count with saturation, synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (inc && (q != MAXV))
            q <= q + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && q != MAXV) |=> (q == $past(q) + 1'b1)); // R8
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q == MAXV) |=> (q == MAXV)); // R9
    AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(q)); // R10

endmodule

// File: rtl/cache_tag_dir.sv
// Set-associative tag directory: hit/miss per request with an
// elaboration-time LRU or FIFO replacement, plus hit/miss counters.
// Assumes: SETS and BLOCK_BYTES are powers of two, SETS >= 2,
// WAYS from 1 to 4; synchronous active-low reset.
module cache_tag_dir #(
    parameter int              ADDR_W      = 32,
    parameter int              SETS        = 16,
    parameter int              WAYS        = 4,
    parameter int              BLOCK_BYTES = 32,
    parameter int              CNT_W       = 32,
    parameter cdir_pkg::repl_e POLICY      = cdir_pkg::REPL_LRU
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_hit,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0][BLK_W-1:0] blk_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];

    logic [IDX_W-1:0]           idx;
    logic [BLK_W-1:0]           key;
    logic [WAYS-1:0][BLK_W-1:0] row_blk;
    logic [WAYS-1:0]            row_vld;
    logic [WAYS-1:0][BLK_W-1:0] nxt_blk;
    logic [WAYS-1:0]            nxt_vld;
    logic                       hit;
    logic [POS_W-1:0]           hit_pos;
    logic                       accept;

    // Address split and request acceptance
    assign idx       = req_addr[OFF_W +: IDX_W];
    assign key       = req_addr[ADDR_W-1:OFF_W];
    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign row_blk   = blk_q[idx];
    assign row_vld   = vld_q[idx];
    assign rsp_hit   = hit;

    cdir_lookup #(.WAYS(WAYS), .BLK_W(BLK_W)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_blk (row_blk),
        .row_vld (row_vld),
        .key     (key),
        .hit     (hit),
        .hit_pos (hit_pos)
    );

    cdir_reorder #(.WAYS(WAYS), .BLK_W(BLK_W), .POLICY(POLICY)) u_reorder (
        .old_blk (row_blk),
        .old_vld (row_vld),
        .hit     (hit),
        .hit_pos (hit_pos),
        .key     (key),
        .new_blk (nxt_blk),
        .new_vld (nxt_vld)
    );

    // Set storage: clear on reset, write back the selected set on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                blk_q[s] <= '0;
                vld_q[s] <= '0;
            end
        end else if (accept) begin
            blk_q[idx] <= nxt_blk;
            vld_q[idx] <= nxt_vld;
        end
    end

    cdir_sat_counter #(.W(CNT_W)) u_hit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept && hit),
        .q     (hit_count)
    );

    cdir_sat_counter #(.W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept && !hit),
        .q     (miss_count)
    );

    // Valid ways stay a contiguous prefix in every set
    for (genvar s = 0; s < SETS; s++) begin : g_chk
        AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
            (((vld_q[s] >> 1) & ~vld_q[s]) == '0)); // R6
    end

    AST_FRONT_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (!hit || POLICY == cdir_pkg::REPL_LRU))
        |=> (blk_q[$past(idx)][0] == $past(key)) && vld_q[$past(idx)][0]); // R4

    AST_MISS_INSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (blk_q[$past(idx)][0] == $past(key))); // R6

    if (POLICY == cdir_pkg::REPL_FIFO) begin : g_fifo_chk
        AST_FIFO_HIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && hit) |=> (blk_q[$past(idx)] == $past(row_blk))
                                && (vld_q[$past(idx)] == $past(row_vld))); // R5
    end

    AST_IDLE_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (blk_q[$past(idx)] == $past(row_blk))
                       && (vld_q[$past(idx)] == $past(row_vld))); // R10

endmodule

// File: tb/cache_tag_dir_bench.sv
// Drives one address stream into LRU, FIFO and direct-mapped copies
// and checks each against a behavioural list model.
module cache_tag_dir_bench;

    localparam int SETS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;

    logic        rdy_l, rdy_f, rdy_d;
    logic        hit_l, hit_f, hit_d;
    logic [31:0] hc_l, mc_l, hc_f, mc_f;
    logic [3:0]  hc_d, mc_d;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state, one entry per copy: 0 LRU, 1 FIFO, 2 direct mapped
    int unsigned mb [3][SETS][4];
    int          mn [3][SETS];
    int          mh [3];
    int          mm [3];
    int          mways [3] = '{4, 4, 1};
    bit          mfifo [3] = '{1'b0, 1'b1, 1'b0};

    always #5 clk = ~clk;

    cache_tag_dir #(.SETS(SETS), .WAYS(4), .BLOCK_BYTES(32), .CNT_W(32),
                    .POLICY(cdir_pkg::REPL_LRU)) u_cache_tag_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(rdy_l), .rsp_hit(hit_l), .hit_count(hc_l), .miss_count(mc_l));

    cache_tag_dir #(.SETS(SETS), .WAYS(4), .BLOCK_BYTES(32), .CNT_W(32),
                    .POLICY(cdir_pkg::REPL_FIFO)) u_cache_tag_dir_fifo (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(rdy_f), .rsp_hit(hit_f), .hit_count(hc_f), .miss_count(mc_f));

    cache_tag_dir #(.SETS(SETS), .WAYS(1), .BLOCK_BYTES(32), .CNT_W(4),
                    .POLICY(cdir_pkg::REPL_LRU)) u_cache_tag_dir_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(rdy_d), .rsp_hit(hit_d), .hit_count(hc_d), .miss_count(mc_d));

    // Record one comparison
    task automatic check(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Build an address from high part, set index and byte offset
    function automatic logic [31:0] mk(input int unsigned hi, input int s, input int off);
        return {hi[24:0], s[1:0], off[4:0]};
    endfunction

    // Reference list update for one copy; returns the expected hit
    task automatic model_step(input int c, input int unsigned blk, input int s,
                              output bit h);
        int p = -1;
        int n;
        for (int k = 0; k < mn[c][s]; k++)
            if (mb[c][s][k] == blk) p = k;
        h = (p >= 0);
        if (h) begin
            mh[c]++;
            if (!mfifo[c]) begin
                for (int k = p; k >= 1; k--) mb[c][s][k] = mb[c][s][k-1];
                mb[c][s][0] = blk;
            end
        end else begin
            mm[c]++;
            n = mn[c][s];
            if (n < mways[c]) n++;
            for (int k = n - 1; k >= 1; k--) mb[c][s][k] = mb[c][s][k-1];
            mb[c][s][0] = blk;
            mn[c][s] = n;
        end
    endtask

    function automatic longint sat4(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    // Counters of every copy against the model
    task automatic check_counts(input string tag);
        check({tag, " lru hits"},  hc_l, mh[0]);
        check({tag, " lru miss"},  mc_l, mm[0]);
        check({tag, " fifo hits"}, hc_f, mh[1]);
        check({tag, " fifo miss"}, mc_f, mm[1]);
        check("R9 dm hits (saturating)", hc_d, sat4(mh[2]));
        check("R9 dm miss (saturating)", mc_d, sat4(mm[2]));
    endtask

    // One accepted request: hit checked before the edge, counters after
    task automatic access(input logic [31:0] a, input string tag);
        bit eh;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        model_step(0, a[31:5], int'(a[6:5]), eh);
        check({tag, " lru hit"}, hit_l, eh);
        model_step(1, a[31:5], int'(a[6:5]), eh);
        check({tag, " fifo hit"}, hit_f, eh);
        model_step(2, a[31:5], int'(a[6:5]), eh);
        check({"R11 ", tag, " dm hit"}, hit_d, eh);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check_counts("R8");
    endtask

    // A cycle with no request, address wiggling
    task automatic idle(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = a;
        @(posedge clk);
        #1;
        check_counts("R10 idle");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) begin
            mh[c] = 0;
            mm[c] = 0;
            for (int s = 0; s < SETS; s++) mn[c][s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R3 reset lru hits", hc_l, 0);
        check("R3 reset lru miss", mc_l, 0);
        check("R3 reset dm miss", mc_d, 0);
        check("R10 ready", {rdy_l, rdy_f, rdy_d}, 3'b111);

        // Directed corner cases
        access(mk(1, 0, 0),  "R3 first access");
        access(mk(1, 0, 31), "R2 same block other offset");
        access(mk(1, 1, 0),  "R2 other set");
        access(mk(1, 0, 4),  "R2 set 0 untouched");
        idle(mk(7, 0, 0));
        access(mk(7, 0, 0),  "R10 idle address not inserted");
        access(mk(32'h0100_0001, 0, 0), "R7 top bit differs");
        access(mk(1, 0, 0),  "R7 original still distinct");
        for (int t = 10; t < 14; t++) access(mk(t, 2, 0), "R6 fill");
        access(mk(10, 2, 8), "R4 R5 hit oldest");
        access(mk(14, 2, 0), "R6 insert fifth");
        access(mk(10, 2, 0), "R4 R5 policy split");
        access(mk(11, 2, 0), "R6 evicted entry");
        access(mk(12, 2, 0), "R4 R5 order after");

        // Random traffic over a small block pool
        for (int i = 0; i < 1500; i++) begin
            int unsigned hi = $urandom_range(0, 6);
            logic [31:0] a;
            if ($urandom_range(0, 15) == 0) hi = hi | 32'h0100_0000;
            a = mk(hi, int'($urandom_range(0, 3)), int'($urandom_range(0, 31)));
            if ($urandom_range(0, 7) == 0)
                idle(a);
            else
                access(a, "R1 random");
        end

        check("R9 dm miss pinned", mc_d, 15);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule